// File: doc/BRIEF.md
# Segmented Binary Counter with Early Event Enable

This block is a wide free-running binary counter built from short segments, so that no carry chain spans the full width. The lowest segment is 4 bits wide and advances on every cycle in which counting is enabled. Each higher segment advances only when a registered advance flag from below is set. That flag is decided one cycle ahead, so the whole value still reads as one true binary count. With the default 32-bit width the segments are 4, 8, 8, 8 and 4 bits wide, from the least significant end.

Next to the counter sits a small controller with an idle and a running state. A 6-bit event counter lives outside the controller. While running, it counts enabled cycles. A flip-flop raises a one-cycle early flag when the event count steps from 59 to 60. The controller's next-state logic sees only that single bit, and the controller drops back to idle on the following clock edge. No compare of the event count feeds the state register through combinational logic.

Top module: `segcnt_top`

## Requirements
- R1: Synchronous active-high reset clears, at the next clock edge, the count, every wrap flag, the early flag, the running state and the event count to zero.
- R2: At each clock edge with `cnt_en` high, `count` becomes its previous value plus one modulo 2^32. This includes the edges at which one or more segments roll over.
- R3: At a clock edge with `cnt_en` low, `count` keeps its value and no wrap flag is raised. When counting resumes after a stall that was held at a rollover point (for example, low 12 bits at 0xFFF), the next enabled edge still gives the previous value plus one.
- R4: `seg_wrap[k]` is high for exactly the one cycle that follows an enabled edge at which segment k rolled from all ones to zero. Bit 0 is the segment at count[3:0], bit 1 is count[11:4], bit 2 is count[19:12], bit 3 is count[27:20] and bit 4 is count[31:28].
- R5: In the idle state (`run` low), a high `start` at a clock edge enters the running state and clears `evt_count` to 0. In the running state, `start` has no effect.
- R6: While running and before the early flag, `evt_count` rises by one at each edge with `cnt_en` high. It holds at edges with `cnt_en` low, and it holds in the idle state.
- R7: `evt_early` goes high for exactly one cycle, in the cycle in which `evt_count` reads 60 (6'b111100). It is set by the enabled edge at which `evt_count` was 59 (6'b111011). A stall with `evt_count` at 59 keeps the flag low.
- R8: At the edge that follows a cycle with `evt_early` high, `run` falls to 0. `evt_count` then holds at 60 while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable for the segmented counter and the event counter |
| start | input | 1 | Starts a run of the controller when idle |
| count | output | 32 | Concatenated segment values, segment 0 in the low bits |
| seg_wrap | output | 5 | One-cycle rollover flag per segment |
| evt_early | output | 1 | Registered early event enable |
| run | output | 1 | Controller state: 1 running, 0 idle |
| evt_count | output | 6 | Event counter value |

## Verification
The assertions assume that `cnt_en`, `start` and `rst` are synchronous to `clk` and settled around each rising edge. They also assume that reset is held high from time zero through at least the first edge, since the step and hold checks compare against the value held before each edge. The bench changes every input only on the falling edge, starts with reset high for several cycles, and holds reset long enough to clear the block again in mid-count. It stalls `cnt_en` both in a pseudo-random pattern and on purpose at the rollover points of the counter and at event count 59.

// File: rtl/segcnt_pkg.sv
package segcnt_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;

    // width of segment k: low segment, middle segments, remainder on top
    function automatic int seg_width(input int k, input int nseg, input int low_w,
                                     input int mid_w, input int total_w);
        if (k == 0) return low_w;
        if (k == nseg - 1) return total_w - low_w - (nseg - 2) * mid_w;
        return mid_w;
    endfunction

    // bit offset of segment k inside the full count
    function automatic int seg_offset(input int k, input int low_w, input int mid_w);
        if (k == 0) return 0;
        return low_w + (k - 1) * mid_w;
    endfunction

endpackage

// File: rtl/segcnt_seg.sv
module segcnt_seg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         adv,
    output logic [W-1:0] val,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         wrap;
    } seg_t;

    seg_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        if (en && adv) begin
            r_d.val  = r_q.val + W'(1);
            r_d.wrap = &r_q.val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign val  = r_q.val;
    assign wrap = r_q.wrap;
endmodule

// File: rtl/segcnt_carry.sv
module segcnt_carry
    import segcnt_pkg::*;
#(
    parameter int TOTAL_W = 32,
    parameter int LOW_W   = 4,
    parameter int MID_W   = 8,
    parameter int NSEG    = 5,
    parameter int LW      = 28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [LW-1:0]   lower,
    output logic [NSEG-1:0] adv
);
    // hit[k]: segment k is at the value that precedes an outgoing carry
    logic [NSEG-2:0] hit;

    for (genvar k = 0; k < NSEG - 1; k++) begin : g_hit
        localparam int W   = seg_width(k, NSEG, LOW_W, MID_W, TOTAL_W);
        localparam int OFF = seg_offset(k, LOW_W, MID_W);
        if (k == 0) begin : g_low
            // low segment one short of all ones: it becomes all ones at this edge
            assign hit[k] = (lower[OFF +: W] == {{(W-1){1'b1}}, 1'b0});
        end else begin : g_mid
            // a middle segment cannot move at an edge where its own carry is set
            assign hit[k] = &lower[OFF +: W];
        end
    end

    logic [NSEG-1:1] carry_q, carry_d;

    always_comb begin
        logic look;
        look    = 1'b1;
        carry_d = carry_q;
        for (int k = 0; k < NSEG - 1; k++) begin
            look = look & hit[k];
            if (en) carry_d[k+1] = look;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) carry_q <= '0;
        else     carry_q <= carry_d;
    end

    assign adv = {carry_q, 1'b1};
endmodule

// File: rtl/segcnt_evt.sv
module segcnt_evt
    import segcnt_pkg::*;
#(
    parameter int EVT_W      = 6,
    parameter int EVT_TARGET = 60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start,
    output logic             early,
    output logic             run,
    output logic [EVT_W-1:0] evt
);
    localparam logic [EVT_W-1:0] EARLY_VAL = EVT_W'(EVT_TARGET - 1);

    typedef struct packed {
        ctl_state_e       state;
        logic [EVT_W-1:0] evt;
        logic             early;
    } ctl_t;

    ctl_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_RUN;
                    r_d.evt   = '0;
                    r_d.early = 1'b0;
                end
            end
            ST_RUN: begin
                if (r_q.early) begin
                    r_d.state = ST_IDLE;
                    r_d.early = 1'b0;
                end else if (en) begin
                    r_d.evt   = r_q.evt + EVT_W'(1);
                    r_d.early = (r_q.evt == EARLY_VAL);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: ST_IDLE, evt: '0, early: 1'b0};
        else     r_q <= r_d;
    end

    assign early = r_q.early;
    assign run   = (r_q.state == ST_RUN);
    assign evt   = r_q.evt;
endmodule

// File: rtl/segcnt_top.sv
module segcnt_top
    import segcnt_pkg::*;
#(
    parameter int TOTAL_W    = 32,
    parameter int LOW_W      = 4,
    parameter int MID_W      = 8,
    parameter int EVT_W      = 6,
    parameter int EVT_TARGET = 60,
    localparam int NSEG      = (TOTAL_W - LOW_W - 1) / MID_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cnt_en,
    input  logic               start,
    output logic [TOTAL_W-1:0] count,
    output logic [NSEG-1:0]    seg_wrap,
    output logic               evt_early,
    output logic               run,
    output logic [EVT_W-1:0]   evt_count
);
    localparam int TOP_W = seg_width(NSEG - 1, NSEG, LOW_W, MID_W, TOTAL_W);
    localparam int LW    = TOTAL_W - TOP_W;

    logic [NSEG-1:0] adv;

    segcnt_carry #(
        .TOTAL_W(TOTAL_W), .LOW_W(LOW_W), .MID_W(MID_W), .NSEG(NSEG), .LW(LW)
    ) u_carry (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .lower (count[LW-1:0]),
        .adv   (adv)
    );

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam int W   = seg_width(k, NSEG, LOW_W, MID_W, TOTAL_W);
        localparam int OFF = seg_offset(k, LOW_W, MID_W);
        segcnt_seg #(.W(W)) u_seg (
            .clk  (clk),
            .rst  (rst),
            .en   (cnt_en),
            .adv  (adv[k]),
            .val  (count[OFF +: W]),
            .wrap (seg_wrap[k])
        );
    end

    segcnt_evt #(.EVT_W(EVT_W), .EVT_TARGET(EVT_TARGET)) u_evt (
        .clk   (clk),
        .rst   (rst),
        .en    (cnt_en),
        .start (start),
        .early (evt_early),
        .run   (run),
        .evt   (evt_count)
    );
endmodule

// File: rtl/segcnt_chk.sv
module segcnt_chk #(
    parameter int TOTAL_W    = 32,
    parameter int LOW_W      = 4,
    parameter int MID_W      = 8,
    parameter int EVT_W      = 6,
    parameter int EVT_TARGET = 60,
    localparam int NSEG      = (TOTAL_W - LOW_W - 1) / MID_W + 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cnt_en,
    input logic               start,
    input logic [TOTAL_W-1:0] count,
    input logic [NSEG-1:0]    seg_wrap,
    input logic               evt_early,
    input logic               run,
    input logic [EVT_W-1:0]   evt_count
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (count == '0 && seg_wrap == '0 && !evt_early && !run && evt_count == '0)); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> count == $past(count) + TOTAL_W'(1)); // R2

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> ($stable(count) && seg_wrap == '0)); // R3

    AST_LOW_WRAP: assert property (@(posedge clk) disable iff (rst)
        seg_wrap[0] |-> count[LOW_W-1:0] == '0); // R4

    for (genvar k = 1; k < NSEG; k++) begin : g_nest
        AST_WRAP_NEST: assert property (@(posedge clk) disable iff (rst)
            seg_wrap[k] |-> seg_wrap[k-1]); // R4
    end

    AST_START_RUN: assert property (@(posedge clk) disable iff (rst)
        (!run && start) |=> (run && evt_count == '0)); // R5

    AST_EVT_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((!run && !start) || (run && !cnt_en)) |=> $stable(evt_count)); // R6

    AST_EARLY_TARGET: assert property (@(posedge clk) disable iff (rst)
        evt_early |-> (run && evt_count == EVT_W'(EVT_TARGET))); // R7

    AST_EARLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        evt_early |=> !evt_early); // R7

    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (rst)
        evt_early |=> !run); // R8
endmodule

bind segcnt_top segcnt_chk #(
    .TOTAL_W(TOTAL_W), .LOW_W(LOW_W), .MID_W(MID_W),
    .EVT_W(EVT_W), .EVT_TARGET(EVT_TARGET)
) u_chk (.*);

// File: tb/segcnt_top_tb.sv
module segcnt_top_tb;
    localparam int NSEG = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        start = 1'b0;
    logic [31:0] count;
    logic [4:0]  seg_wrap;
    logic        evt_early;
    logic        run;
    logic [5:0]  evt_count;

    int tests = 0;
    int fails = 0;
    int mism  = 0;
    int wmism = 0;
    int wraps1 = 0;
    logic [31:0] bad_cnt, bad_ref;

    segcnt_top u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .start(start),
        .count(count), .seg_wrap(seg_wrap), .evt_early(evt_early),
        .run(run), .evt_count(evt_count)
    );

    always #5 clk = ~clk;

    // independent reference: plain 32-bit counter and rollover flags
    logic [31:0]     ref_cnt = '0;
    logic [NSEG-1:0] ref_wrap = '0;

    function automatic bit low_ones(input logic [31:0] v, input int k);
        int          top_bit;
        logic [63:0] mask;
        top_bit = (k == NSEG - 1) ? 32 : 4 + 8 * k;
        mask    = (64'd1 << top_bit) - 64'd1;
        return (({32'd0, v} & mask) == mask);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ref_cnt  <= '0;
            ref_wrap <= '0;
        end else begin
            if (cnt_en) ref_cnt <= ref_cnt + 32'd1;
            for (int k = 0; k < NSEG; k++) ref_wrap[k] <= cnt_en && low_ones(ref_cnt, k);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (count !== ref_cnt) begin
                if (mism == 0) begin bad_cnt = count; bad_ref = ref_cnt; end
                mism++;
            end
            if (seg_wrap !== ref_wrap) wmism++;
            if (seg_wrap[1]) wraps1++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // R1: reset state, while held and after a mid-count reset
    task automatic t_reset();
        @(negedge clk);
        check(count == 0 && seg_wrap == 0, "R1 count/wrap in reset", {count, 27'd0, seg_wrap}, 0);
        check(!evt_early && !run && evt_count == 0, "R1 ctl in reset",
              {evt_early, run, evt_count}, 0);
        rst = 1'b0;
    endtask

    // R2, R4: steady counting across the first middle-segment rollover
    task automatic t_steady();
        int m0 = mism, w0 = wmism;
        cnt_en = 1'b1;
        repeat (5000) @(negedge clk);
        check(count == 32'd5000, "R2 count after 5000 enabled edges", count, 5000);
        check(mism == m0, "R2 per-cycle match to reference", bad_cnt, bad_ref);
        check(wmism == w0, "R4 wrap flags match reference", wmism - w0, 0);
        check(wraps1 == 1, "R4 segment 1 rolled once", wraps1, 1);
        // mid-count reset
        rst = 1'b1;
        @(negedge clk);
        check(count == 0 && seg_wrap == 0 && !run, "R1 mid-count reset", count, 0);
        rst = 1'b0;
    endtask

    // R3: stall exactly at a rollover point, then random stalls
    task automatic t_stall();
        logic [31:0] held;
        logic [15:0] lfsr = 16'hACE1;
        int m0;
        cnt_en = 1'b1;
        while (count[11:0] != 12'hFFF) @(negedge clk);
        cnt_en = 1'b0;
        held   = count;
        repeat (4) @(negedge clk);
        check(count == held, "R3 held during stall at 0xFFF", count, held);
        check(seg_wrap == 0, "R3 no wrap flag during stall", seg_wrap, 0);
        cnt_en = 1'b1;
        @(negedge clk);
        check(count == held + 32'd1, "R3 resume across carry", count, held + 32'd1);
        check(seg_wrap == 5'b00011, "R4 low and segment 1 wrap together", seg_wrap, 5'b00011);
        m0 = mism;
        for (int i = 0; i < 60000; i++) begin
            lfsr   = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cnt_en = lfsr[0] | lfsr[3];
            @(negedge clk);
        end
        check(mism == m0, "R3 random stalls match reference", bad_cnt, bad_ref);
        cnt_en = 1'b1;
    endtask

    // R5-R8: full run with an ignored start and a stall
    task automatic t_fsm();
        int  early_cnt = 0;
        int  exit_cyc  = 0;
        bit  prev_early = 1'b0;
        cnt_en = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(run && evt_count == 0, "R5 start enters run with count 0", {run, evt_count}, 7'h40);
        for (int cyc = 1; cyc <= 200 && exit_cyc == 0; cyc++) begin
            @(negedge clk);
            if (cyc == 21) begin
                check(evt_count == 6'd21, "R5 start ignored while running", evt_count, 21);
                start = 1'b0;
            end
            if (cyc == 20) start = 1'b1;
            if (cyc == 30) cnt_en = 1'b0;
            if (cyc == 33) begin
                check(evt_count == 6'd30, "R6 event count holds in stall", evt_count, 30);
                cnt_en = 1'b1;
            end
            if (evt_early) begin
                early_cnt++;
                check(evt_count == 6'd60, "R7 early flag with count 60", evt_count, 60);
            end
            if (!run) begin
                exit_cyc = cyc;
                check(prev_early, "R8 exit follows early flag", prev_early, 1);
            end
            prev_early = evt_early;
        end
        check(early_cnt == 1, "R7 early flag lasts one cycle", early_cnt, 1);
        check(exit_cyc == 64, "R8 exit cycle", exit_cyc, 64);
        repeat (3) @(negedge clk);
        check(!run && evt_count == 6'd60, "R8 count holds while idle", {run, evt_count}, 60);
    endtask

    // R7: stall while the event count sits at 59
    task automatic t_fsm_stall();
        bit ok = 1'b1;
        cnt_en = 1'b1;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (evt_count != 6'd59) @(negedge clk);
        check(!evt_early, "R7 no early flag at 59", evt_early, 0);
        cnt_en = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (evt_early || evt_count != 6'd59 || !run) ok = 1'b0;
        end
        check(ok, "R7 stall at 59 keeps flag low", {evt_early, evt_count}, 59);
        cnt_en = 1'b1;
        @(negedge clk);
        check(evt_early && evt_count == 6'd60, "R7 flag after resume", {evt_early, evt_count}, 7'h7C);
        @(negedge clk);
        check(!run && !evt_early, "R8 idle after flag", {run, evt_early}, 0);
        check(mism == 0, "R2 whole run matches reference", bad_cnt, bad_ref);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_steady();
        t_stall();
        t_fsm();
        t_fsm_stall();
        summary();
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R1..R8 actual=timeout expected=done");
        summary();
        $finish;
    end
endmodule